// File: doc/BRIEF.md
# Oversampled Serial Receive Engine with Line-Error and Address Detection

This block turns an asynchronous serial line into characters. An enable pulse at sixteen times the bit rate paces it. It confirms each start bit at mid-bit and then samples every later bit at the centre of its cell. It assembles five to eight data bits, least significant bit first. After the data it may take a ninth bit, which is either a parity bit or a multi-drop address marker, and it then checks the stop bit. Each completed character is presented for one clock together with its parity, framing and break indications.

Sticky error flags collect these indications. A separate run-length timer catches a line that is held low for longer than a whole frame. The flags stay set until the owner clears them with a one-cycle clear pulse. The line can be complemented before sampling. In multi-drop address mode the ninth bit marks address characters. A matching address opens a gate for the data characters that follow, and a mismatching address closes it. Baud-rate generation, FIFO storage and any register interface sit outside the block.

Top module: `serial_rx_engine`

## Requirements
- R1: Data bits are assembled least significant bit first into `char_data`. `cfg_wlen` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits above the word length read as 0.
- R2: In idle, a tick that sees the line low begins a start bit. The line is sampled again on the 8th tick after that one. If it is high, the character is dropped without a strobe. Each later bit is sampled 16 ticks after the previous sample.
- R3: With `cfg_par_en`=1 and `cfg_par_stick`=0, a ninth bit follows the data. `char_perr` is 1 when the total count of ones in the data and the ninth bit is odd with `cfg_par_even`=1, or even with `cfg_par_even`=0.
- R4: With `cfg_par_stick`=1, the ninth bit must be 0 when `cfg_par_even`=1 and must be 1 when `cfg_par_even`=0. Any other value sets `char_perr`.
- R5: `char_ferr` is 1 when the stop sample is 0. After such a character, no new start bit is accepted until a tick has seen the line high.
- R6: `char_brk` is 1 when every sample of the frame is 0, from the start bit through the stop bit. Such a character also has `char_ferr` set.
- R7: Let F = 16 × (2 + word length + ninth bit present). `err_break` sets on the (F+1)th consecutive tick that sees the line low. A low run of exactly F ticks leaves it clear.
- R8: `err_parity`, `err_frame`, `err_break` and `addr_seen` are sticky. They are cleared by `clr_flags` bits 0, 1, 2 and 3 respectively, and a set in the same cycle wins over the clear. `line_status` is the OR of the three error flags.
- R9: With `cfg_addr_mode` and `cfg_addr_enable` both 1, a ninth bit is always taken and parity is not checked. A character whose ninth bit is 1 is an address and sets `addr_seen`. An address equal to `cfg_match` is delivered and opens the gate; any other address is dropped and closes the gate. A character whose ninth bit is 0 is delivered only while the gate is open, and the gate is closed after reset.
- R10: With `cfg_invert`=1, the line is complemented before sampling.
- R11: `char_valid` is high for one clock, the clock after the tick that samples the stop bit. Error flags from dropped characters do not reach the sticky flags.
- R12: After reset all outputs are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| rx_line | input | 1 | Serial input |
| cfg_invert | input | 1 | Complement the line |
| cfg_wlen | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity / stick value select |
| cfg_par_stick | input | 1 | Fixed-value parity |
| cfg_addr_mode | input | 1 | Multi-drop address filtering |
| cfg_addr_enable | input | 1 | Address detection enable |
| cfg_match | input | 8 | Station address |
| clr_flags | input | 4 | Clear pulses: parity, framing, break, address |
| char_valid | output | 1 | Character strobe |
| char_data | output | 8 | Received data |
| char_perr | output | 1 | Parity error of this character |
| char_ferr | output | 1 | Framing error of this character |
| char_brk | output | 1 | All-zero frame |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky timed break |
| addr_seen | output | 1 | Sticky address-character seen |
| line_status | output | 1 | OR of the sticky error flags |

## Verification
Any internal slip shows up within one frame, because the bench model predicts every output on every clock. A bit counter or sample phase that is off by one moves the strobe to a different clock, or corrupts `char_data` at the next character. A wrong gate or address decision appears as a missing or extra strobe at the first data character after an address. A break-timer error shows as `err_break` rising one tick early or late at the exact-frame-length boundary.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  // word length code 0..3 -> 5..8 data bits
  function automatic logic [3:0] word_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/srx_line_cond.sv
module srx_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic invert,
  output logic rx_clean
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  // R10: complement before the synchronizer so idle stays high inside
  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], rx_pin ^ invert};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign rx_clean = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        wlen,
  input  logic              ninth_en,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ninth_bit,
  output logic              all_zero
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID_CNT = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] END_CNT = CW'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ninth_q, ninth_d;
  logic              zero_q, zero_d;
  logic [IW-1:0]     last_idx;

  assign last_idx = IW'(word_bits(wlen) - 4'd1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    ninth_d = ninth_q;
    zero_d  = zero_q;
    done    = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rx) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            if (rx) begin
              state_d = ST_IDLE;           // R2: glitch rejected
            end else begin
              state_d = ST_DATA;
              idx_d   = '0;
              data_d  = '0;
              ninth_d = 1'b0;
              zero_d  = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == END_CNT) begin
            cnt_d         = '0;
            data_d[idx_q] = rx;              // R1: LSB first
            zero_d        = zero_q & ~rx;
            if (idx_q == last_idx) state_d = ninth_en ? ST_NINTH : ST_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_NINTH: begin
          if (cnt_q == END_CNT) begin
            cnt_d   = '0;
            ninth_d = rx;
            zero_d  = zero_q & ~rx;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == END_CNT) begin
            cnt_d   = '0;
            done    = 1'b1;
            state_d = rx ? ST_IDLE : ST_HOLD;  // R5: wait for high after bad stop
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (rx) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      ninth_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      ninth_q <= ninth_d;
      zero_q  <= zero_d;
    end
  end

  assign data      = data_q;
  assign ninth_bit = ninth_q;
  assign all_zero  = zero_q;

  // R2: data phase is entered only after a low mid-bit start sample
  a_r2_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> $past(!rx));

  // R5: a character with a low stop sample blocks the next start
  a_r5_hold_after_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rx) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/srx_break_det.sv
module srx_break_det
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] wlen,
  input  logic       ninth_en,
  output logic       brk_event
);
  localparam int BW = $clog2(OSR * (DATA_W + 3) + 1);

  logic [BW-1:0] run_q, run_d;
  logic          seen_q, seen_d;
  logic [BW-1:0] frame_len;

  // R7: start + data + optional ninth + stop, in ticks
  assign frame_len = BW'(OSR) * (BW'(word_bits(wlen)) + BW'(ninth_en) + BW'(2));

  always_comb begin
    run_d     = run_q;
    seen_d    = seen_q;
    brk_event = 1'b0;
    if (tick) begin
      if (rx) begin
        run_d  = '0;
        seen_d = 1'b0;
      end else if (run_q < frame_len) begin
        run_d = run_q + BW'(1);
      end else if (!seen_q) begin
        brk_event = 1'b1;
        seen_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      seen_q <= seen_d;
    end
  end

  // R7: one event per low run
  a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |=> !brk_event);
endmodule

// File: rtl/srx_result.sv
module srx_result
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              ninth_bit,
  input  logic              all_zero,
  input  logic              stop_bit,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              addr_mode,
  input  logic [DATA_W-1:0] match,
  input  logic              brk_event,
  input  logic [3:0]        clr_flags,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              char_brk,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break,
  output logic              addr_seen,
  output logic              line_status
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              perr_q, perr_d, ferr_q, ferr_d, brk_q, brk_d;
  logic              sp_q, sp_d, sf_q, sf_d, sb_q, sb_d, sa_q, sa_d;
  logic              gate_q, gate_d;
  logic              ones_odd, perr_calc, match_hit, deliver, take;

  assign ones_odd  = ^data ^ ninth_bit;
  // R3, R4: normal and stick parity; R9: no check in address mode
  assign perr_calc = par_en & ~addr_mode &
                     (par_stick ? (ninth_bit == par_even)
                                : (par_even ? ones_odd : ~ones_odd));
  assign match_hit = (data == match);
  assign deliver   = ~addr_mode | (ninth_bit ? match_hit : gate_q);
  assign take      = done & deliver;

  always_comb begin
    gate_d  = gate_q;
    if (!addr_mode)              gate_d = 1'b0;
    else if (done && ninth_bit)  gate_d = match_hit;

    valid_d = take;                                  // R11
    data_d  = take ? data : data_q;
    perr_d  = take ? perr_calc : perr_q;
    ferr_d  = take ? ~stop_bit : ferr_q;             // R5
    brk_d   = take ? (all_zero & ~stop_bit) : brk_q; // R6

    // R8: sticky, set wins over clear
    sp_d = (sp_q & ~clr_flags[0]) | (take & perr_calc);
    sf_d = (sf_q & ~clr_flags[1]) | (take & ~stop_bit);
    sb_d = (sb_q & ~clr_flags[2]) | brk_event;
    sa_d = (sa_q & ~clr_flags[3]) | (done & addr_mode & ninth_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
      sp_q    <= 1'b0;
      sf_q    <= 1'b0;
      sb_q    <= 1'b0;
      sa_q    <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      brk_q   <= brk_d;
      sp_q    <= sp_d;
      sf_q    <= sf_d;
      sb_q    <= sb_d;
      sa_q    <= sa_d;
      gate_q  <= gate_d;
    end
  end

  assign char_valid  = valid_q;
  assign char_data   = data_q;
  assign char_perr   = perr_q;
  assign char_ferr   = ferr_q;
  assign char_brk    = brk_q;
  assign err_parity  = sp_q;
  assign err_frame   = sf_q;
  assign err_break   = sb_q;
  assign addr_seen   = sa_q;
  assign line_status = sp_q | sf_q | sb_q;

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

  a_r6_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_brk) |-> char_ferr);

  a_r8_frame_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !clr_flags[1]) |=> err_frame);

  a_r9_foreign_address_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (done && addr_mode && ninth_bit && data != match) |=> !char_valid);

  a_r3_no_parity_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_en) |=> !char_perr);
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              cfg_invert,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_addr_mode,
  input  logic              cfg_addr_enable,
  input  logic [DATA_W-1:0] cfg_match,
  input  logic [3:0]        clr_flags,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              char_brk,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break,
  output logic              addr_seen,
  output logic              line_status
);
  logic              rx_s;
  logic              addr_on;
  logic              ninth_en;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_ninth;
  logic              f_zero;
  logic              brk_ev;

  assign addr_on  = cfg_addr_mode & cfg_addr_enable;
  assign ninth_en = cfg_par_en | addr_on;

  srx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_line), .invert(cfg_invert), .rx_clean(rx_s)
  );

  srx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .wlen(cfg_wlen), .ninth_en(ninth_en),
    .done(f_done), .data(f_data), .ninth_bit(f_ninth), .all_zero(f_zero)
  );

  srx_break_det #(.OSR(OSR)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .wlen(cfg_wlen), .ninth_en(ninth_en), .brk_event(brk_ev)
  );

  srx_result u_res (
    .clk(clk), .rst_n(rst_n), .done(f_done), .data(f_data), .ninth_bit(f_ninth),
    .all_zero(f_zero), .stop_bit(rx_s),
    .par_en(cfg_par_en), .par_even(cfg_par_even), .par_stick(cfg_par_stick),
    .addr_mode(addr_on), .match(cfg_match), .brk_event(brk_ev), .clr_flags(clr_flags),
    .char_valid(char_valid), .char_data(char_data), .char_perr(char_perr),
    .char_ferr(char_ferr), .char_brk(char_brk),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .addr_seen(addr_seen), .line_status(line_status)
  );
endmodule

// File: tb/serial_rx_engine_test.sv
module serial_rx_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       cfg_invert = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0;
  logic       cfg_addr_mode = 1'b0, cfg_addr_enable = 1'b0;
  logic [7:0] cfg_match = 8'h00;
  logic [3:0] clr_flags = 4'h0;
  logic       char_valid, char_perr, char_ferr, char_brk;
  logic [7:0] char_data;
  logic       err_parity, err_frame, err_break, addr_seen, line_status;

  int checks = 0, errors = 0, tick_div = 0, finished = 0;
  int got_n = 0, got_d = 0, got_pe = 0, got_fe = 0, got_be = 0;

  // reference model state
  int m_s1, m_s2, m_busy, m_ts, m_hold, m_run, m_gate;
  int m_valid, m_data, m_cpe, m_cfe, m_cbe, m_pe, m_fe, m_be, m_ae;
  logic [11:0] m_fb;

  serial_rx_engine uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 4;
    os_tick <= (tick_div == 0);
  end

  // behavioural reference: frame positions counted in ticks since start detection
  always @(posedge clk or negedge rst_n) begin
    int rxq, nb, nin, tot, k, ones, pb, stopv, allz, perr, deliver, amode, fin, d;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_ts = 0; m_hold = 0; m_run = 0; m_gate = 0;
      m_valid = 0; m_data = 0; m_cpe = 0; m_cfe = 0; m_cbe = 0;
      m_pe = 0; m_fe = 0; m_be = 0; m_ae = 0; m_fb = '0;
    end else begin
      rxq = m_s2; m_s2 = m_s1; m_s1 = rx_line ^ cfg_invert;
      amode = cfg_addr_mode & cfg_addr_enable;
      nb = 5 + cfg_wlen; nin = cfg_par_en | amode; tot = 2 + nb + nin;
      fin = 0;
      if (clr_flags[0]) m_pe = 0;
      if (clr_flags[1]) m_fe = 0;
      if (clr_flags[2]) m_be = 0;
      if (clr_flags[3]) m_ae = 0;
      if (os_tick) begin
        if (rxq) m_run = 0;
        else begin m_run++; if (m_run == 16 * tot + 1) m_be = 1; end
        if (m_busy) begin
          m_ts++;
          if (m_ts >= 8 && (m_ts - 8) % 16 == 0) begin
            k = (m_ts - 8) / 16;
            m_fb[k] = rxq[0];
            if (k == 0 && rxq) m_busy = 0;
            else if (k == tot - 1) begin fin = 1; m_busy = 0; m_hold = !rxq; end
          end
        end else if (m_hold) begin
          if (rxq) m_hold = 0;
        end else if (!rxq) begin
          m_busy = 1; m_ts = 0;
        end
      end
      m_valid = 0;
      if (fin) begin
        d = 0;
        for (int i = 0; i < nb; i++) if (m_fb[1+i]) d += (1 << i);
        pb = nin ? int'(m_fb[1+nb]) : 0;
        stopv = m_fb[tot-1];
        allz = 1;
        for (int i = 0; i < tot; i++) if (m_fb[i]) allz = 0;
        ones = pb;
        for (int i = 0; i < 8; i++) ones += (d >> i) & 1;
        perr = 0;
        if (cfg_par_en && !amode)
          perr = cfg_par_stick ? (pb == cfg_par_even) : (cfg_par_even ? ones % 2 : 1 - ones % 2);
        if (!amode) deliver = 1;
        else if (pb) deliver = (d == cfg_match);
        else deliver = m_gate;
        if (amode && pb) begin m_gate = (d == cfg_match); m_ae = 1; end
        if (deliver) begin
          m_valid = 1; m_data = d; m_cpe = perr; m_cfe = !stopv; m_cbe = allz;
          if (perr) m_pe = 1;
          if (!stopv) m_fe = 1;
        end
      end
      if (!amode) m_gate = 0;
    end
  end

  // cycle-by-cycle comparison and capture
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 strobe", char_valid, m_valid);
      if (m_valid) begin
        chk("R1 data", char_data, m_data);
        chk("R3 char parity", char_perr, m_cpe);
        chk("R5 char framing", char_ferr, m_cfe);
        chk("R6 char break", char_brk, m_cbe);
      end
      chk("R8 sticky parity", err_parity, m_pe);
      chk("R8 sticky framing", err_frame, m_fe);
      chk("R7 sticky break", err_break, m_be);
      chk("R9 address seen", addr_seen, m_ae);
      chk("R8 line status", line_status, m_pe | m_fe | m_be);
      if (char_valid) begin
        got_n++; got_d = char_data; got_pe = char_perr; got_fe = char_ferr; got_be = char_brk;
      end
    end
  end

  task automatic drive_bit(input logic v);
    rx_line = v ^ cfg_invert;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input int d, input int nb, input int has9, input int b9, input int stopv);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(((d >> i) & 1) != 0);
    if (has9) drive_bit(b9 != 0);
    drive_bit(stopv != 0);
    repeat (3) drive_bit(1'b1);
  endtask

  task automatic clear(input logic [3:0] m);
    clr_flags = m;
    @(negedge clk);
    clr_flags = 4'h0;
    @(negedge clk);
  endtask

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    // R12: reset state
    chk("R12 valid", char_valid, 0);
    chk("R12 data", char_data, 0);
    chk("R12 flags", {err_parity, err_frame, err_break, addr_seen, line_status}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: word lengths
    n0 = got_n;
    send(8'hA5, 8, 0, 0, 1);
    chk("R11 one char", got_n - n0, 1);
    chk("R1 8-bit", got_d, 8'hA5);
    cfg_wlen = 2'd0; send(8'h13, 5, 0, 0, 1); chk("R1 5-bit", got_d, 8'h13);
    cfg_wlen = 2'd1; send(8'h2A, 6, 0, 0, 1); chk("R1 6-bit", got_d, 8'h2A);
    cfg_wlen = 2'd2; send(8'h5B, 7, 0, 0, 1); chk("R1 7-bit", got_d, 8'h5B);
    cfg_wlen = 2'd3;

    // R3: normal parity
    cfg_par_en = 1; cfg_par_even = 1;
    send(8'hA5, 8, 1, 0, 1); chk("R3 even ok", got_pe, 0);
    send(8'hA5, 8, 1, 1, 1); chk("R3 even bad", got_pe, 1);
    chk("R8 parity sticky", err_parity, 1);
    cfg_par_even = 0;
    send(8'h07, 8, 1, 0, 1); chk("R3 odd ok", got_pe, 0);

    // R4: stick parity
    cfg_par_stick = 1; cfg_par_even = 1;
    send(8'h01, 8, 1, 0, 1); chk("R4 stick zero ok", got_pe, 0);
    send(8'h01, 8, 1, 1, 1); chk("R4 stick zero bad", got_pe, 1);
    cfg_par_even = 0;
    send(8'h01, 8, 1, 1, 1); chk("R4 stick one ok", got_pe, 0);
    cfg_par_en = 0; cfg_par_stick = 0;
    clear(4'hF);
    chk("R8 cleared", {err_parity, line_status}, 0);

    // R2: start glitch
    n0 = got_n;
    rx_line = 1'b0; repeat (16) @(negedge clk);
    rx_line = 1'b1; repeat (192) @(negedge clk);
    chk("R2 glitch dropped", got_n - n0, 0);
    send(8'h3C, 8, 0, 0, 1); chk("R2 after glitch", got_d, 8'h3C);

    // R5: framing error and rearm
    send(8'h55, 8, 0, 0, 0);
    chk("R5 framing", got_fe, 1);
    chk("R6 not break", got_be, 0);
    chk("R8 line status", line_status, 1);
    send(8'h66, 8, 0, 0, 1); chk("R5 rearm", got_d, 8'h66);
    clear(4'hF);

    // R6/R7: all-zero frame of exactly F low ticks
    send(8'h00, 8, 0, 0, 0);
    chk("R6 break char", got_be, 1);
    chk("R6 with framing", got_fe, 1);
    chk("R7 boundary", err_break, 0);

    // R7: long low run
    rx_line = 1'b0; repeat (768) @(negedge clk);
    rx_line = 1'b1; repeat (256) @(negedge clk);
    chk("R7 timed break", err_break, 1);
    clear(4'h4);
    chk("R8 break cleared", err_break, 0);
    chk("R8 framing kept", err_frame, 1);
    clear(4'hF);

    // R10: inverted line
    cfg_invert = 1; rx_line = 1'b0;
    repeat (8) @(negedge clk);
    send(8'hC3, 8, 0, 0, 1); chk("R10 inverted", got_d, 8'hC3);
    cfg_invert = 0; rx_line = 1'b1;
    repeat (8) @(negedge clk);

    // R9: address filtering
    cfg_addr_mode = 1; cfg_addr_enable = 1; cfg_match = 8'h3C;
    cfg_par_en = 1; cfg_par_even = 1;
    n0 = got_n;
    send(8'h11, 8, 1, 0, 1); chk("R9 gate closed", got_n - n0, 0);
    send(8'h22, 8, 1, 1, 1); chk("R9 foreign address", got_n - n0, 0);
    chk("R9 address flag", addr_seen, 1);
    send(8'h3C, 8, 1, 1, 1); chk("R9 own address", got_d, 8'h3C);
    send(8'h98, 8, 1, 0, 1); chk("R9 data passes", got_d, 8'h98);
    chk("R9 no parity check", got_pe, 0);
    chk("R9 count", got_n - n0, 2);
    send(8'h22, 8, 1, 1, 1);
    send(8'h44, 8, 1, 0, 1); chk("R9 gate reclosed", got_n - n0, 2);
    clear(4'h8);
    chk("R8 address cleared", addr_seen, 0);

    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule